// File: doc/BRIEF.md
# Multiplexed-Bus Byte RAM with I/O Register Window

This block is a clocked model of a 256-byte static memory that hangs off a processor bus where address and data share the same eight lines. At the start of each bus cycle the processor raises an address strobe. While that strobe is high the block tracks the shared lines, the chip-enable input and the space-select input. When the strobe falls it holds all three. The read and write strobes that follow then act on the held location.

The space-select input steers each access to one of two targets. One is the byte array. The other is a small window of byte registers in a separate I/O space. A build parameter sets whether the chip enable is active high or active low. The shared bus is split into an input byte, an output byte and an output-enable flag. A surrounding pad ring or bus fabric joins them. The reset input is asynchronous and active low, and it is released on the clock. Reset clears the held address, the held selection and the I/O registers. It leaves the array contents alone.

Top module: `mbus_sram_if`

## Requirements
- R1: While `ale` is high, the held address, enable and space follow the bus inputs on every clock. After `ale` falls they keep the last values sampled with `ale` high.
- R2: `ad_oe` is 1 only while the held selection is active and `rd_n` is low. Whenever `ad_oe` is 0, `ad_out` is 0.
- R3: A write commits on the first clock where `wr_n` is seen high after being low. It stores the last bus byte seen during the low phase, at the held address.
- R4: If `rd_n` is low in any clock of a write strobe, that write is dropped, and the target keeps its old value.
- R5: With `io_m`=1, I/O addresses 0 to 5 each reach a byte register that can be written and read back.
- R6: With `io_m`=1, writes to I/O addresses 6 and above change nothing, and reads there return 0.
- R7: Reset clears the held selection and address, so a read strobe without a new `ale` leaves `ad_oe` at 0. Reset also clears all I/O registers to 0.
- R8: Reset leaves the byte array contents unchanged.
- R9: If the enable held at `ale` is inactive, reads do not drive the bus and writes change nothing.
- R10: With `CE_ACTIVE_HIGH`=1 the chip is selected by `ce`=1. With `CE_ACTIVE_HIGH`=0 it is selected by `ce`=0.
- R11: An I/O-space write leaves the array byte at the same address unchanged, and an array write leaves the I/O registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address strobe; holds address, enable and space when it falls |
| io_m | input | 1 | Space select: 1 = I/O registers, 0 = byte array |
| ce | input | 1 | Chip enable, polarity set by CE_ACTIVE_HIGH |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| ad_in | input | 8 | Shared bus, incoming byte |
| ad_out | output | 8 | Shared bus, outgoing byte |
| ad_oe | output | 1 | Shared bus output enable |

## Verification
The hardest cases to reach from the ports come from strobe timing, not from data. The first is a write strobe that overlaps a read strobe. It should leave memory untouched, and only a later clean read can show that. The second is an address that changes while `ale` is still high. The stimulus builds both cases on purpose. It drives both strobes low for one full write phase. It also shifts the bus byte partway through a two-cycle `ale` pulse. A read-back then confirms that the old value survived or that the second address was held. Two instances with opposite enable polarity see the same bus, and for part of the run only one of them is selected.

// File: rtl/mbus_sram_pkg.sv
package mbus_sram_pkg;

  typedef enum logic {
    SPACE_MEM = 1'b0,
    SPACE_IO  = 1'b1
  } space_e;

endpackage

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch #(
  parameter int AW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ale,
  input  logic                      sel_in,
  input  mbus_sram_pkg::space_e     space_in,
  input  logic [AW-1:0]             addr_in,
  output logic                      sel_o,
  output mbus_sram_pkg::space_e     space_o,
  output logic [AW-1:0]             addr_o,
  output logic                      sel_held_o
);
  import mbus_sram_pkg::*;

  logic          sel_q, sel_d;
  space_e        space_q, space_d;
  logic [AW-1:0] addr_q, addr_d;

  always_comb begin
    sel_d   = sel_q;
    space_d = space_q;
    addr_d  = addr_q;
    if (ale) begin
      sel_d   = sel_in;
      space_d = space_in;
      addr_d  = addr_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      space_q <= SPACE_MEM;
      addr_q  <= '0;
    end else if (ale) begin
      sel_q   <= sel_d;
      space_q <= space_d;
      addr_q  <= addr_d;
    end
  end

  assign sel_o      = ale ? sel_in   : sel_q;
  assign space_o    = ale ? space_in : space_q;
  assign addr_o     = ale ? addr_in  : addr_q;
  assign sel_held_o = sel_q;

endmodule

// File: rtl/mbus_strobe_ctl.sv
module mbus_strobe_ctl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] bus_in,
  output logic          commit_o,
  output logic [DW-1:0] wdata_o,
  output logic          oe_o
);

  logic          wr_low_q, wr_low_d;
  logic          clash_q, clash_d;
  logic [DW-1:0] data_q;
  logic          wr_act;

  assign wr_act = sel & ~wr_n;

  always_comb begin
    wr_low_d = wr_act;
    clash_d  = 1'b0;
    if (wr_act) begin
      clash_d = clash_q | ~rd_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_low_q <= 1'b0;
      clash_q  <= 1'b0;
    end else begin
      wr_low_q <= wr_low_d;
      clash_q  <= clash_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (wr_act) begin
      data_q <= bus_in;
    end
  end

  assign commit_o = wr_low_q & wr_n & ~clash_q;
  assign wdata_o  = data_q;
  assign oe_o     = sel & ~rd_n;

endmodule

// File: rtl/mbus_ram_array.sv
module mbus_ram_array #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/mbus_io_regs.sv
module mbus_io_regs #(
  parameter int DW     = 8,
  parameter int AW     = 8,
  parameter int N_REGS = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] regs_q [N_REGS];

  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    logic hit;
    assign hit = we && (addr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (hit) begin
        regs_q[g] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_REGS; i++) begin
      if (addr == AW'(i)) begin
        rdata = regs_q[i];
      end
    end
  end

endmodule

// File: rtl/mbus_sram_if.sv
module mbus_sram_if #(
  parameter bit CE_ACTIVE_HIGH = 1'b0,
  parameter int DW             = 8,
  parameter int AW             = 8,
  parameter int N_IO_REGS      = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ale,
  input  logic          io_m,
  input  logic          ce,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe
);
  import mbus_sram_pkg::*;

  logic [1:0]    rst_sync_q;
  logic          rst_int;
  logic          ce_act;
  space_e        space_in, space;
  logic          sel, sel_held;
  logic [AW-1:0] addr;
  logic          commit, oe;
  logic [DW-1:0] wdata, mem_rdata, io_rdata;
  logic          mem_we, io_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int = rst_sync_q[1];

  if (CE_ACTIVE_HIGH) begin : g_ce_high
    assign ce_act = ce;
  end else begin : g_ce_low
    assign ce_act = ~ce;
  end

  assign space_in = io_m ? SPACE_IO : SPACE_MEM;

  mbus_addr_latch #(.AW(AW)) u_latch (
    .clk        (clk),
    .rst_n      (rst_int),
    .ale        (ale),
    .sel_in     (ce_act),
    .space_in   (space_in),
    .addr_in    (ad_in[AW-1:0]),
    .sel_o      (sel),
    .space_o    (space),
    .addr_o     (addr),
    .sel_held_o (sel_held)
  );

  mbus_strobe_ctl #(.DW(DW)) u_strobe (
    .clk      (clk),
    .rst_n    (rst_int),
    .sel      (sel),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .bus_in   (ad_in),
    .commit_o (commit),
    .wdata_o  (wdata),
    .oe_o     (oe)
  );

  assign mem_we = commit && (space == SPACE_MEM);
  assign io_we  = commit && (space == SPACE_IO);

  mbus_ram_array #(.DW(DW), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .addr  (addr),
    .wdata (wdata),
    .rdata (mem_rdata)
  );

  mbus_io_regs #(.DW(DW), .AW(AW), .N_REGS(N_IO_REGS)) u_io (
    .clk   (clk),
    .rst_n (rst_int),
    .we    (io_we),
    .addr  (addr),
    .wdata (wdata),
    .rdata (io_rdata)
  );

  always_comb begin
    ad_out = '0;
    if (oe) begin
      ad_out = (space == SPACE_IO) ? io_rdata : mem_rdata;
    end
  end
  assign ad_oe = oe;

endmodule

// File: rtl/mbus_sram_if_chk.sv
module mbus_sram_if_chk (
  input logic clk,
  input logic rst_int,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic sel,
  input logic sel_held,
  input logic ad_oe,
  input logic mem_we,
  input logic io_we
);

  AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_int)
    ad_oe |-> !rd_n);  // R2

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_int)
    !sel |-> !ad_oe);  // R9

  AST_WRITE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_int)
    (mem_we || io_we) |-> (wr_n && $past(!wr_n)));  // R3

  AST_NO_WRITE_ON_CLASH: assert property (@(posedge clk) disable iff (!rst_int)
    (sel && !wr_n && !rd_n) |=> !(mem_we || io_we));  // R4

  AST_RESET_DESELECTS: assert property (@(posedge clk) disable iff (!rst_int)
    $rose(rst_int) |-> !sel_held);  // R7

endmodule

bind mbus_sram_if mbus_sram_if_chk u_chk (
  .clk      (clk),
  .rst_int  (rst_int),
  .ale      (ale),
  .rd_n     (rd_n),
  .wr_n     (wr_n),
  .sel      (sel),
  .sel_held (sel_held),
  .ad_oe    (ad_oe),
  .mem_we   (mem_we),
  .io_we    (io_we)
);

// File: tb/mbus_sram_if_tb_top.sv
module mbus_sram_if_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ale = 1'b0, io_m = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic       ce_l = 1'b1, ce_h = 1'b0;
  logic [7:0] ad_in = 8'h00;
  logic [7:0] out_l, out_h;
  logic       oe_l, oe_h;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  mbus_sram_if #(.CE_ACTIVE_HIGH(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .ale(ale), .io_m(io_m), .ce(ce_l),
    .rd_n(rd_n), .wr_n(wr_n), .ad_in(ad_in), .ad_out(out_l), .ad_oe(oe_l));

  mbus_sram_if #(.CE_ACTIVE_HIGH(1'b1)) dut_h (
    .clk(clk), .rst_n(rst_n), .ale(ale), .io_m(io_m), .ce(ce_h),
    .rd_n(rd_n), .wr_n(wr_n), .ad_in(ad_in), .ad_out(out_h), .ad_oe(oe_h));

  typedef struct {
    logic       oe_l;
    logic [7:0] d_l;
    logic       oe_h;
    logic [7:0] d_h;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  event mon_ev;

  logic [7:0] ram_m [256];
  logic [7:0] io_r  [6];

  // Monitor: pops expected items and compares both instances
  initial begin
    forever begin
      @(mon_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (oe_l !== e.oe_l || out_l !== e.d_l) begin
          errors++;
          $display("FAIL %s ce-low: oe=%0b data=%02h expected oe=%0b data=%02h",
                   e.req, oe_l, out_l, e.oe_l, e.d_l);
        end
        checks++;
        if (oe_h !== e.oe_h || out_h !== e.d_h) begin
          errors++;
          $display("FAIL %s ce-high: oe=%0b data=%02h expected oe=%0b data=%02h",
                   e.req, oe_h, out_h, e.oe_h, e.d_h);
        end
      end
    end
  end

  task automatic addr_phase(bit io, bit cel, bit ceh, logic [7:0] a);
    @(negedge clk);
    ale = 1'b1; io_m = io; ce_l = cel; ce_h = ceh; ad_in = a;
    @(negedge clk);
    ale = 1'b0;
  endtask

  task automatic bus_write(bit io, bit en, logic [7:0] a, logic [7:0] d, bit clash);
    addr_phase(io, ~en, en, a);
    ad_in = d; wr_n = 1'b0;
    if (clash) rd_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    if (en && !clash) begin
      if (io) begin
        if (a < 8'd6) io_r[a] = d;
      end else begin
        ram_m[a] = d;
      end
    end
  endtask

  function automatic logic [7:0] model_read(bit io, logic [7:0] a);
    if (io) return (a < 8'd6) ? io_r[a] : 8'h00;
    return ram_m[a];
  endfunction

  task automatic push_sample(logic oel, logic [7:0] dl, logic oeh, logic [7:0] dh, string req);
    exp_t e;
    e.oe_l = oel; e.d_l = dl; e.oe_h = oeh; e.d_h = dh; e.req = req;
    rd_n = 1'b0;
    #1;
    exp_q.push_back(e);
    ->mon_ev;
    @(negedge clk);
    rd_n = 1'b1;
  endtask

  task automatic bus_read(bit io, bit en, logic [7:0] a, string req);
    logic [7:0] d;
    addr_phase(io, ~en, en, a);
    d = en ? model_read(io, a) : 8'h00;
    push_sample(en, d, en, d, req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 6; i++) io_r[i] = 8'h00;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    do_reset();

    // R7: after reset, a read strobe without a new address phase drives nothing
    push_sample(1'b0, 8'h00, 1'b0, 8'h00, "R7 no-select after reset");
    // R7 / R5: I/O registers are cleared by reset
    for (int i = 0; i < 6; i++) bus_read(1'b1, 1'b1, 8'(i), "R7 io clear");

    // R3: array write/read patterns, including the end addresses
    bus_write(1'b0, 1'b1, 8'h00, 8'hA5, 1'b0);
    bus_write(1'b0, 1'b1, 8'hFF, 8'h3C, 1'b0);
    bus_write(1'b0, 1'b1, 8'h5A, 8'hFF, 1'b0);
    bus_write(1'b0, 1'b1, 8'h03, 8'h00, 1'b0);
    bus_write(1'b0, 1'b1, 8'h04, 8'h81, 1'b0);
    bus_read(1'b0, 1'b1, 8'h00, "R3 addr 00");
    bus_read(1'b0, 1'b1, 8'hFF, "R3 addr FF");
    bus_read(1'b0, 1'b1, 8'h5A, "R3 addr 5A");

    // R5: I/O registers hold written values
    for (int i = 0; i < 6; i++) bus_write(1'b1, 1'b1, 8'(i), 8'(8'h10 + 8'(i * 17)), 1'b0);
    for (int i = 0; i < 6; i++) bus_read(1'b1, 1'b1, 8'(i), "R5 io readback");

    // R6: out-of-window I/O writes are ignored and read as zero
    bus_write(1'b1, 1'b1, 8'h06, 8'hEE, 1'b0);
    bus_write(1'b1, 1'b1, 8'hC8, 8'h77, 1'b0);
    bus_read(1'b1, 1'b1, 8'h06, "R6 io addr 6");
    bus_read(1'b1, 1'b1, 8'hC8, "R6 io addr C8");

    // R11: I/O writes at 03/04 left array bytes alone, array writes left io regs alone
    bus_read(1'b0, 1'b1, 8'h03, "R11 array under io 3");
    bus_read(1'b0, 1'b1, 8'h04, "R11 array under io 4");
    bus_write(1'b0, 1'b1, 8'h02, 8'h99, 1'b0);
    bus_read(1'b1, 1'b1, 8'h02, "R11 io 2 after array write");

    // R4: overlapping read and write strobes drop the write
    bus_write(1'b0, 1'b1, 8'h10, 8'h42, 1'b0);
    bus_write(1'b0, 1'b1, 8'h10, 8'hBD, 1'b1);
    bus_read(1'b0, 1'b1, 8'h10, "R4 clash keeps old");
    bus_write(1'b1, 1'b1, 8'h01, 8'h00, 1'b1);
    bus_read(1'b1, 1'b1, 8'h01, "R4 clash io");

    // R9: deselected accesses neither drive nor write
    bus_write(1'b0, 1'b1, 8'h20, 8'h11, 1'b0);
    bus_write(1'b0, 1'b0, 8'h20, 8'h99, 1'b0);
    bus_read(1'b0, 1'b0, 8'h20, "R9 deselected read");
    bus_read(1'b0, 1'b1, 8'h20, "R9 deselected write ignored");

    // R1: address follows bus while ale high, holds after it falls
    bus_write(1'b0, 1'b1, 8'h30, 8'h5C, 1'b0);
    bus_write(1'b0, 1'b1, 8'h31, 8'hC5, 1'b0);
    @(negedge clk);
    ale = 1'b1; io_m = 1'b0; ce_l = 1'b0; ce_h = 1'b1; ad_in = 8'h30;
    @(negedge clk);
    ad_in = 8'h31;
    @(negedge clk);
    ale = 1'b0; ad_in = 8'h30;
    push_sample(1'b1, 8'hC5, 1'b1, 8'hC5, "R1 latch tracks then holds");

    // R10: same raw ce value selects only the matching polarity
    addr_phase(1'b0, 1'b1, 1'b1, 8'h00);
    push_sample(1'b0, 8'h00, 1'b1, ram_m[0], "R10 ce=1");
    addr_phase(1'b0, 1'b0, 1'b0, 8'hFF);
    push_sample(1'b1, ram_m[255], 1'b0, 8'h00, "R10 ce=0");

    // R8 / R7: reset mid-run keeps the array, clears I/O
    do_reset();
    push_sample(1'b0, 8'h00, 1'b0, 8'h00, "R7 no-select after second reset");
    bus_read(1'b0, 1'b1, 8'h00, "R8 array kept 00");
    bus_read(1'b0, 1'b1, 8'h5A, "R8 array kept 5A");
    bus_read(1'b1, 1'b1, 8'h05, "R7 io 5 cleared");

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule